// File: doc/BRIEF.md
# Command Packet Decoder and Register Writer

This block sits behind a command-word fetcher and turns a stream of 32-bit words into packets. It accepts one word per clock while `word_valid` is high. Every packet starts with a header word and is followed by the payload words that the header announces. The block holds the packet state between words, so packets can span idle cycles.

Register-write packets come in two forms: a burst that writes consecutive register indices, and a pair that writes two independently chosen indices. Both turn into single-cycle write strobes on a register port. Opcode packets consume their payload words. Some opcodes also raise a side request: an indirect-buffer fetch, a state-invalidate mask or an inline-index draw trigger. Filler headers are single words and do nothing. The block does not check whether the stream is well formed. It trusts the counts in the headers.

Top module: `cmd_packet_decoder`

## Requirements
- R1: A word on `word_data` holds four bytes in memory order, with the lowest-addressed byte in bits [7:0]. The block reads them as a big-endian command word, so that byte is command bit field [31:24].
- R2: The command's bits [31:30] select the packet kind: 0 = burst, 1 = pair, 2 = filler, 3 = opcode. A burst header carries a payload count of bits [29:16] plus one and a start index in bits [15:0]. Payload word m is written to index start+m.
- R3: A pair header carries its first index in bits [10:0] and its second in bits [21:11]. Exactly two payload words follow and are written to the first and then the second index.
- R4: A write whose index is at or above `REG_COUNT` produces no `reg_we` strobe, but its payload word is still consumed.
- R5: A filler header is one word with no payload and produces no output.
- R6: An opcode header carries the opcode in bits [15:8] and a payload count of bits [29:16] plus one. For the no-op opcode 0x10, and for the other recognised opcodes with no side request, every payload word is consumed and nothing is output.
- R7: For the indirect-buffer opcode 0x3F, `ib_req` pulses for one cycle after the second payload word. At that point `ib_addr` equals the first payload word and `ib_len` equals the second. A packet with only one payload word raises no request.
- R8: For the invalidate opcode 0x3B, `inv_pulse` pulses for one cycle after the first payload word, with `inv_mask` equal to that word.
- R9: For the inline-draw opcode 0x36, `draw_pulse` pulses for one cycle after the first payload word, with `draw_count` equal to that word's bits [31:16].
- R10: An opcode outside the recognised set (0x10, 0x21, 0x22, 0x27, 0x2B, 0x36, 0x3B, 0x3C, 0x3F, 0x45, 0x46, 0x48, 0x58) has its payload skipped. It also sets `unk_op` in the cycle after its header, and `unk_op` stays set until reset.
- R11: Each strobe or pulse appears in the cycle after the clock edge that accepts its word. At most one of them is high in any cycle. A cycle with `word_valid` low changes no output.
- R12: While reset is asserted and right after it, every strobe, pulse and flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_valid | input | 1 | A command word is present this cycle |
| word_data | input | 32 | Command word in memory byte order |
| reg_we | output | 1 | Register write strobe |
| reg_idx | output | IDX_W | Register index of the write |
| reg_wdata | output | 32 | Register write data |
| ib_req | output | 1 | Indirect-buffer fetch request pulse |
| ib_addr | output | 32 | Indirect list pointer |
| ib_len | output | 32 | Indirect list length in words |
| inv_pulse | output | 1 | State-invalidate pulse |
| inv_mask | output | 32 | State-invalidate mask |
| draw_pulse | output | 1 | Inline-index draw trigger |
| draw_count | output | 16 | Index count of the draw |
| unk_op | output | 1 | Sticky unknown-opcode flag |

## Verification
Each word's effect is due exactly one clock after the edge that accepts it. This holds for register strobes, the side-request pulses and the unknown-opcode flag alike. The flag rises one cycle after its header, and the indirect request follows the second payload word rather than the first. The bench drives a word five nanoseconds after a rising edge and samples all outputs five nanoseconds after the next rising edge. In that sample it compares every pulse and the flag against the single expected effect of that word. Idle cycles are sampled the same way to confirm that nothing moves.

// File: rtl/cmd_packet_decoder.sv
module cmd_packet_decoder #(
  parameter int REG_COUNT = 8192,
  parameter int IDX_W     = 16,
  parameter int CNT_W     = 14,
  parameter logic [7:0] OPC_NOP  = 8'h10,
  parameter logic [7:0] OPC_IB   = 8'h3F,
  parameter logic [7:0] OPC_INV  = 8'h3B,
  parameter logic [7:0] OPC_DRAW = 8'h36
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             word_valid,
  input  logic [31:0]      word_data,
  output logic             reg_we,
  output logic [IDX_W-1:0] reg_idx,
  output logic [31:0]      reg_wdata,
  output logic             ib_req,
  output logic [31:0]      ib_addr,
  output logic [31:0]      ib_len,
  output logic             inv_pulse,
  output logic [31:0]      inv_mask,
  output logic             draw_pulse,
  output logic [15:0]      draw_count,
  output logic             unk_op
);

  typedef enum logic [1:0] {M_IDLE, M_BURST, M_PAIR, M_OPC} mode_t;

  localparam logic [IDX_W:0] REG_LIM = (IDX_W+1)'(REG_COUNT);
  localparam logic [CNT_W:0] ONE     = (CNT_W+1)'(1);

  mode_t          mode;
  logic [CNT_W:0] left, pos;
  logic [IDX_W:0] burst_idx;
  logic [10:0]    pair_a, pair_b;
  logic [7:0]     opc;
  logic [31:0]    first_word;
  logic [31:0]    cmd;
  logic [10:0]    pair_sel;
  logic [IDX_W:0] pair_ext;

  assign cmd      = {word_data[7:0], word_data[15:8], word_data[23:16], word_data[31:24]};
  assign pair_sel = (pos == '0) ? pair_a : pair_b;
  assign pair_ext = (IDX_W+1)'(pair_sel);

  function automatic logic op_known(input logic [7:0] o);
    case (o)
      OPC_NOP, OPC_IB, OPC_INV, OPC_DRAW,
      8'h21, 8'h22, 8'h27, 8'h2B, 8'h3C, 8'h45, 8'h46, 8'h48, 8'h58: op_known = 1'b1;
      default: op_known = 1'b0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode       <= M_IDLE;
      left       <= '0;
      pos        <= '0;
      burst_idx  <= '0;
      pair_a     <= '0;
      pair_b     <= '0;
      opc        <= '0;
      first_word <= '0;
      reg_we     <= 1'b0;
      reg_idx    <= '0;
      reg_wdata  <= '0;
      ib_req     <= 1'b0;
      ib_addr    <= '0;
      ib_len     <= '0;
      inv_pulse  <= 1'b0;
      inv_mask   <= '0;
      draw_pulse <= 1'b0;
      draw_count <= '0;
      unk_op     <= 1'b0;
    end else begin
      reg_we     <= 1'b0;
      ib_req     <= 1'b0;
      inv_pulse  <= 1'b0;
      draw_pulse <= 1'b0;
      if (word_valid) begin
        if (mode == M_IDLE) begin
          pos <= '0;
          case (cmd[31:30])
            2'd0: begin
              mode      <= M_BURST;
              left      <= {1'b0, cmd[29:16]} + ONE;
              burst_idx <= {1'b0, cmd[15:0]};
            end
            2'd1: begin
              mode   <= M_PAIR;
              left   <= (CNT_W+1)'(2);
              pair_a <= cmd[10:0];
              pair_b <= cmd[21:11];
            end
            2'd3: begin
              mode <= M_OPC;
              left <= {1'b0, cmd[29:16]} + ONE;
              opc  <= cmd[15:8];
              if (!op_known(cmd[15:8])) unk_op <= 1'b1;
            end
            default: ;
          endcase
        end else begin
          left <= left - ONE;
          pos  <= pos + ONE;
          if (left == ONE) mode <= M_IDLE;
          case (mode)
            M_BURST: begin
              reg_idx   <= burst_idx[IDX_W-1:0];
              reg_wdata <= cmd;
              reg_we    <= burst_idx < REG_LIM;
              burst_idx <= burst_idx + 1'b1;
            end
            M_PAIR: begin
              reg_idx   <= pair_ext[IDX_W-1:0];
              reg_wdata <= cmd;
              reg_we    <= pair_ext < REG_LIM;
            end
            M_OPC: begin
              if (pos == '0) begin
                first_word <= cmd;
                if (opc == OPC_INV) begin
                  inv_mask  <= cmd;
                  inv_pulse <= 1'b1;
                end
                if (opc == OPC_DRAW) begin
                  draw_count <= cmd[31:16];
                  draw_pulse <= 1'b1;
                end
              end
              if (pos == ONE && opc == OPC_IB) begin
                ib_addr <= first_word;
                ib_len  <= cmd;
                ib_req  <= 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  // R11
  one_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_we, ib_req, inv_pulse, draw_pulse}));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(word_valid) |-> !(reg_we || ib_req || inv_pulse || draw_pulse));

  // R4
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> ({1'b0, reg_idx} < REG_LIM));

  // R10
  unk_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unk_op |=> unk_op);

  // R7
  ib_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ib_req |=> !ib_req);

  // R8
  inv_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_pulse |=> !inv_pulse);

endmodule

// File: tb/cmd_packet_decoder_tb.sv
module cmd_packet_decoder_tb_top;
  localparam int REGS = 1500;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_valid = 1'b0;
  logic [31:0] word_data = '0;
  logic        reg_we, ib_req, inv_pulse, draw_pulse, unk_op;
  logic [15:0] reg_idx, draw_count;
  logic [31:0] reg_wdata, ib_addr, ib_len, inv_mask;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic        e_we, e_ib, e_inv, e_draw, e_unk;
  logic [15:0] e_idx, e_cnt;
  logic [31:0] e_dat, e_ia, e_il, e_mask;

  always #10 clk = ~clk;

  cmd_packet_decoder #(.REG_COUNT(REGS)) dut_i (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_data(word_data),
    .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .ib_req(ib_req), .ib_addr(ib_addr), .ib_len(ib_len),
    .inv_pulse(inv_pulse), .inv_mask(inv_mask),
    .draw_pulse(draw_pulse), .draw_count(draw_count), .unk_op(unk_op));

  function automatic logic [31:0] to_mem(input logic [31:0] c);
    return {c[7:0], c[15:8], c[23:16], c[31:24]};
  endfunction

  function automatic bit known(input logic [7:0] o);
    case (o)
      8'h10, 8'h21, 8'h22, 8'h27, 8'h2B, 8'h36, 8'h3B,
      8'h3C, 8'h3F, 8'h45, 8'h46, 8'h48, 8'h58: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic clear_exp();
    e_we = 0; e_ib = 0; e_inv = 0; e_draw = 0;
  endtask

  task automatic step(input logic v, input logic [31:0] c, input string tag);
    logic [4:0] got, exp;
    word_valid = v;
    word_data  = to_mem(c);
    @(posedge clk);
    #5;
    got = {reg_we, ib_req, inv_pulse, draw_pulse, unk_op};
    exp = {e_we, e_ib, e_inv, e_draw, e_unk};
    chk(got == exp, {tag, " R11 pulses"}, 64'(got), 64'(exp));
    if (e_we)   chk(reg_idx == e_idx && reg_wdata == e_dat, {tag, " write"},
                    {16'h0, reg_idx, reg_wdata}, {16'h0, e_idx, e_dat});
    if (e_ib)   chk(ib_addr == e_ia && ib_len == e_il, {tag, " R7 indirect"},
                    {ib_addr, ib_len}, {e_ia, e_il});
    if (e_inv)  chk(inv_mask == e_mask, {tag, " R8 mask"}, 64'(inv_mask), 64'(e_mask));
    if (e_draw) chk(draw_count == e_cnt, {tag, " R9 count"}, 64'(draw_count), 64'(e_cnt));
    clear_exp();
  endtask

  task automatic burst(input int base, input int n, input string tag);
    step(1, {2'b00, 14'(n - 1), 16'(base)}, tag);
    for (int m = 0; m < n; m++) begin
      logic [31:0] d = $urandom;
      e_we = (base + m) < REGS; e_idx = 16'(base + m); e_dat = d;
      step(1, d, tag);
    end
  endtask

  task automatic pair(input int a, input int b, input string tag);
    logic [31:0] d;
    step(1, {2'b01, 8'($urandom), 11'(b), 11'(a)}, tag);
    d = $urandom; e_we = a < REGS; e_idx = 16'(a); e_dat = d;
    step(1, d, tag);
    d = $urandom; e_we = b < REGS; e_idx = 16'(b); e_dat = d;
    step(1, d, tag);
  endtask

  task automatic opcode(input logic [7:0] op, input int n, input string tag);
    logic [31:0] w0;
    if (!known(op)) e_unk = 1;
    step(1, {2'b11, 14'(n - 1), op, 8'($urandom)}, tag);
    w0 = '0;
    for (int p = 0; p < n; p++) begin
      logic [31:0] d = $urandom;
      if (p == 0) w0 = d;
      if (p == 0 && op == 8'h3B) begin e_inv = 1; e_mask = d; end
      if (p == 0 && op == 8'h36) begin e_draw = 1; e_cnt = d[31:16]; end
      if (p == 1 && op == 8'h3F) begin e_ib = 1; e_ia = w0; e_il = d; end
      step(1, d, tag);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R11 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    clear_exp(); e_unk = 0; e_idx = 0; e_dat = 0; e_ia = 0; e_il = 0; e_mask = 0; e_cnt = 0;
    repeat (3) @(posedge clk);
    #5;
    chk({reg_we, ib_req, inv_pulse, draw_pulse, unk_op} == 5'b0, "R12 in reset", 64'(unk_op), 0);
    rst_n = 1'b1;
    @(posedge clk); #5;
    chk({reg_we, ib_req, inv_pulse, draw_pulse, unk_op} == 5'b0, "R12 after reset", 64'(unk_op), 0);

    // R1: known byte order
    step(1, 32'h0000_0005, "R1");
    e_we = 1; e_idx = 16'h5; e_dat = 32'h1122_3344;
    step(1, 32'h1122_3344, "R1");
    burst(10, 5, "R2");
    burst(REGS - 2, 4, "R4 edge");
    burst(65534, 3, "R4 wrap");
    pair(7, 1400, "R3");
    pair(1499, 1500, "R4 pair");
    step(1, 32'h8000_1234, "R5");
    step(0, 32'hFFFF_FFFF, "R11 idle");
    opcode(8'h10, 4, "R6");
    opcode(8'h48, 3, "R6 other");
    opcode(8'h3F, 2, "R7");
    opcode(8'h3F, 1, "R7 short");
    opcode(8'h3F, 5, "R7 long");
    opcode(8'h3B, 1, "R8");
    opcode(8'h36, 3, "R9");
    opcode(8'h77, 2, "R10");
    burst(3, 2, "R10 after");

    for (int k = 0; k < 400; k++) begin
      int sel = $urandom_range(0, 6);
      case (sel)
        0: burst(($urandom_range(0, 1) != 0) ? $urandom_range(REGS - 8, REGS + 4)
                                           : $urandom_range(0, 65535),
                 $urandom_range(1, 6), "R2 rnd");
        1: pair($urandom_range(0, 2047), $urandom_range(0, 2047), "R3 rnd");
        2: step(1, {2'b10, 30'($urandom)}, "R5 rnd");
        3: step(0, $urandom, "R11 rnd");
        4: opcode(($urandom_range(0, 1) != 0) ? 8'h3F : 8'h3B, $urandom_range(1, 4), "R7 rnd");
        5: opcode(($urandom_range(0, 1) != 0) ? 8'h36 : 8'h10, $urandom_range(1, 4), "R9 rnd");
        default: opcode(8'($urandom), $urandom_range(1, 4), "R10 rnd");
      endcase
    end
    word_valid = 0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule